// File: doc/BRIEF.md
# Multichannel Conversion Sequencer

This block drives an external successive-approximation converter through a one-cycle start pulse and a done pulse that carries the result. Software programs it through a plain single-cycle register port. Reads are combinational on the address, and any side effect of a read takes place at the clock edge where the read strobe is high. The block holds one result word per input, one word for the most recent result, an interrupt-enable mask, a status word and a control word.

The control word sets several things. It picks which inputs may be converted and the divider for the converter clock enable. It sets the accuracy field, which is passed through to the converter, and the power bit. It sets a burst flag and a start source with its edge polarity. A conversion starts on a software "start now" request, on a synchronised edge of one of five trigger inputs, or back to back in burst mode. Each input has a done flag and an overrun flag. The done flags, gated by the enable mask, are ORed into one interrupt line.

Top module: `conv_seq`

## Requirements
- R1: After reset every register reads zero, `irq` is 0 and `conv_start` is 0.
- R2: While power (control bit 21) is set, `conv_clk_en` pulses once every N+1 cycles, where N is control bits 15:8. While power is clear it stays 0.
- R3: No conversion starts while control bit 21 is clear.
- R4: Start-source code 1 (control bits 26:24) converts the lowest selected input (control bits 7:0) exactly once. The code then reads back as 0.
- R5: Start-source codes 2 to 6 start a conversion on an edge of `trig_in[code-2]`, after a two-flop synchroniser. Control bit 27 picks the edge: 0 is rising, 1 is falling. The other edge and edges on other trigger inputs start nothing.
- R6: With burst (control bit 16) set, selected inputs are converted back to back in ascending order. Each one is the next selected index above the last converted input, wrapping to the lowest selected index.
- R7: The result word of input i is at address 8+i. It holds the 10-bit result in bits 15:6, the overrun flag in bit 30 and the done flag in bit 31.
- R8: Address 1 holds the latest result from any input. The result is in bits 15:6, the input index in bits 26:24 and a done bit in bit 31. Reading address 1 clears that done bit.
- R9: Reading the result word of an input clears its done and overrun flags. A new result for an input whose done flag is still set raises its overrun flag.
- R10: The status word at address 3 holds the done flags in bits 7:0, the overrun flags in bits 15:8 and the interrupt in bit 16. `irq` is the OR of the done flags masked by the enable word at address 2.
- R11: `conv_bits` always equals control bits 19:17.
- R12: With start-source code 0 or 7 and burst clear, no conversion starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| trig_in | input | 5 | Asynchronous hardware trigger inputs |
| conv_clk_en | output | 1 | Divided converter clock enable |
| conv_bits | output | 3 | Accuracy setting for the converter |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Input index being converted |
| conv_done | input | 1 | Converter result valid pulse |
| conv_result | input | 10 | Converter result |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is an overrun. It needs two completed conversions on the same input with no read in between, and the input must then be read while both flags are still visible. The stimulus starts "start now" conversions twice on one input and checks the status word and `irq` before the read and after it. Burst order is observed through a bench converter model that logs every requested index.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
    typedef enum logic [0:0] {SQ_IDLE, SQ_BUSY} sq_state_e;
    localparam int A_CTRL     = 0;
    localparam int A_GLOBAL   = 1;
    localparam int A_IEN      = 2;
    localparam int A_STATUS   = 3;
    localparam int A_RES_BASE = 8;
    localparam logic [31:0] CTRL_WMASK = 32'h0F2F_FFFF;
endpackage

// File: rtl/cseq_clkdiv.sv
module cseq_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= div_n) begin
            st_d.cnt  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div_n != '0 && tick) |=> !tick); // R2
endmodule

// File: rtl/cseq_trig_sync.sv
module cseq_trig_sync #(
    parameter int NTRIG = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] trig_in,
    output logic [NTRIG-1:0] rise,
    output logic [NTRIG-1:0] fall
);
    typedef struct packed {
        logic [NTRIG-1:0] s1;
        logic [NTRIG-1:0] s2;
        logic [NTRIG-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = trig_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NTRIG; g++) begin : g_edge
        assign rise[g] =  st_q.s2[g] & ~st_q.s3[g];
        assign fall[g] = ~st_q.s2[g] &  st_q.s3[g];
    end
endmodule

// File: rtl/cseq_chan_pick.sv
module cseq_chan_pick #(
    parameter int NCH  = 8,
    parameter int CH_W = 3
) (
    input  logic [NCH-1:0]  mask,
    input  logic [CH_W-1:0] last,
    output logic            any,
    output logic [CH_W-1:0] lowest,
    output logic [CH_W-1:0] next
);
    always_comb begin
        any    = |mask;
        lowest = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i]) lowest = CH_W'(i);
        end
        next = lowest;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask[i] && i > int'(last)) next = CH_W'(i);
        end
    end
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
    parameter int NCH    = 8,
    parameter int RES_W  = 10,
    parameter int NTRIG  = 5,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    input  logic [NTRIG-1:0]           trig_in,
    output logic                       conv_clk_en,
    output logic [2:0]                 conv_bits,
    output logic                       conv_start,
    output logic [$clog2(NCH)-1:0]     conv_chan,
    input  logic                       conv_done,
    input  logic [RES_W-1:0]           conv_result,
    output logic                       irq
);
    import cseq_pkg::*;

    localparam int CH_W = $clog2(NCH);

    typedef struct packed {
        logic [31:0]                 ctrl;
        logic [NCH-1:0]              ien;
        logic [NCH-1:0][RES_W-1:0]   res;
        logic [NCH-1:0]              done;
        logic [NCH-1:0]              ovr;
        logic [RES_W-1:0]            g_res;
        logic [CH_W-1:0]             g_ch;
        logic                        g_done;
        sq_state_e                   state;
        logic [CH_W-1:0]             chan;
        logic [CH_W-1:0]             last;
        logic                        start;
    } seq_t;

    seq_t st_d, st_q;

    logic [NTRIG-1:0] t_rise, t_fall;
    logic             sel_any;
    logic [CH_W-1:0]  sel_low, sel_next;
    logic             edge_hit;
    logic [2:0]       src;
    logic             pwr, burst;
    logic [NCH-1:0]   rd_clr;

    assign src   = st_q.ctrl[26:24];
    assign pwr   = st_q.ctrl[21];
    assign burst = st_q.ctrl[16];

    cseq_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(pwr),
        .div_n(st_q.ctrl[8 +: DIV_W]), .tick(conv_clk_en)
    );

    cseq_trig_sync #(.NTRIG(NTRIG)) u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .rise(t_rise), .fall(t_fall)
    );

    cseq_chan_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
        .mask(st_q.ctrl[NCH-1:0]), .last(st_q.last),
        .any(sel_any), .lowest(sel_low), .next(sel_next)
    );

    always_comb begin
        edge_hit = 1'b0;
        for (int t = 0; t < NTRIG; t++) begin
            if (int'(src) == t + 2)
                edge_hit = st_q.ctrl[27] ? t_fall[t] : t_rise[t];
        end
        rd_clr = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_en && int'(addr) == A_RES_BASE + i) rd_clr[i] = 1'b1;
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.done  = st_q.done & ~rd_clr;
        st_d.ovr   = st_q.ovr  & ~rd_clr;
        if (rd_en && int'(addr) == A_GLOBAL) st_d.g_done = 1'b0;
        if (wr_en && int'(addr) == A_CTRL)   st_d.ctrl = wdata & CTRL_WMASK;
        if (wr_en && int'(addr) == A_IEN)    st_d.ien  = wdata[NCH-1:0];
        case (st_q.state)
            SQ_IDLE: begin
                if (pwr && sel_any && (burst || src == 3'd1 || edge_hit)) begin
                    st_d.state = SQ_BUSY;
                    st_d.start = 1'b1;
                    st_d.chan  = burst ? sel_next : sel_low;
                    st_d.last  = burst ? sel_next : sel_low;
                end
            end
            default: begin
                if (conv_done) begin
                    st_d.res[st_q.chan]  = conv_result;
                    st_d.ovr[st_q.chan]  = st_q.done[st_q.chan] & ~rd_clr[st_q.chan];
                    st_d.done[st_q.chan] = 1'b1;
                    st_d.g_res  = conv_result;
                    st_d.g_ch   = st_q.chan;
                    st_d.g_done = 1'b1;
                    st_d.state  = SQ_IDLE;
                    if (!burst && src == 3'd1 && !(wr_en && int'(addr) == A_CTRL))
                        st_d.ctrl[26:24] = 3'd0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_CTRL:   rdata = st_q.ctrl;
            A_GLOBAL: begin
                rdata[6 +: RES_W] = st_q.g_res;
                rdata[24 +: CH_W] = st_q.g_ch;
                rdata[31]         = st_q.g_done;
            end
            A_IEN:    rdata[NCH-1:0] = st_q.ien;
            A_STATUS: begin
                rdata[NCH-1:0]  = st_q.done;
                rdata[8 +: NCH] = st_q.ovr;
                rdata[16]       = irq;
            end
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (int'(addr) == A_RES_BASE + i) begin
                        rdata[6 +: RES_W] = st_q.res[i];
                        rdata[30]         = st_q.ovr[i];
                        rdata[31]         = st_q.done[i];
                    end
                end
            end
        endcase
    end

    assign conv_start = st_q.start;
    assign conv_chan  = st_q.chan;
    assign conv_bits  = st_q.ctrl[19:17];
    assign irq        = |(st_q.done & st_q.ien);

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R4
    AST_START_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(st_q.ctrl[21])); // R3
    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == SQ_BUSY && conv_done) |=> st_q.done[$past(st_q.chan)]); // R7
    AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr & ~$past(st_q.ovr) & ~$past(st_q.done)) == '0); // R9
endmodule

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [4:0]  trig_in = '0;
    logic        conv_clk_en, conv_start, conv_done = 1'b0, irq;
    logic [2:0]  conv_bits, conv_chan;
    logic [9:0]  conv_result = '0;

    int n_chk = 0, n_err = 0;
    int seq = 0;
    logic [2:0] chan_log [0:63];

    localparam logic [31:0] PWR = 32'h0020_0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_seq u_conv_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trig_in(trig_in), .conv_clk_en(conv_clk_en),
        .conv_bits(conv_bits), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
    );

    // behavioural converter: result = {index, 7-bit sequence number}
    initial begin
        forever begin
            @(negedge clk);
            if (conv_start) begin
                logic [2:0] ch;
                ch = conv_chan;
                chan_log[seq[5:0]] = ch;
                repeat (3) @(negedge clk);
                conv_result = {ch, 7'(seq)};
                conv_done = 1'b1;
                seq++;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] res_word(input int idx, input logic [2:0] ch,
                                             input logic ovr, input logic dn);
        logic [31:0] w;
        w = '0;
        w[15:6] = {ch, 7'(idx)};
        w[30] = ovr;
        w[31] = dn;
        return w;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(4'd0, d);  chk("R1 ctrl", d, 0);
        bus_rd(4'd1, d);  chk("R1 global", d, 0);
        bus_rd(4'd3, d);  chk("R1 status", d, 0);
        bus_rd(4'd12, d); chk("R1 result4", d, 0);
        chk("R1 irq", {31'b0, irq}, 0);
        chk("R1 start", {31'b0, conv_start}, 0);
    endtask

    task automatic t_divider();
        int cnt;
        bus_wr(4'd0, 32'h0000_0300 | (32'd5 << 17));
        cnt = 0;
        repeat (40) begin @(negedge clk); if (conv_clk_en) cnt++; end
        chk("R2 unpowered ticks", cnt, 0);
        chk("R11 accuracy field", {29'b0, conv_bits}, 5);
        bus_wr(4'd0, 32'h0000_0300 | PWR);
        repeat (8) @(negedge clk);
        cnt = 0;
        repeat (40) begin @(negedge clk); if (conv_clk_en) cnt++; end
        chk("R2 ticks per 40 cycles, N=3", cnt, 10);
    endtask

    task automatic t_no_start();
        int s0;
        s0 = seq;
        bus_wr(4'd0, 32'h0100_0008);          // start now, no power
        repeat (20) @(negedge clk);
        chk("R3 no conversion unpowered", seq, s0);
        bus_wr(4'd0, 32'h0000_0008 | PWR);    // code 0
        repeat (20) @(negedge clk);
        chk("R12 code 0 idle", seq, s0);
        bus_wr(4'd0, 32'h0700_0008 | PWR);    // code 7
        repeat (20) @(negedge clk);
        chk("R12 code 7 idle", seq, s0);
    endtask

    task automatic t_start_now();
        logic [31:0] d;
        int s0;
        s0 = seq;
        bus_wr(4'd0, 32'h0100_0028 | PWR);    // inputs 3 and 5
        repeat (20) @(negedge clk);
        chk("R4 single conversion", seq, s0 + 1);
        chk("R4 lowest input", {29'b0, chan_log[s0[5:0]]}, 3);
        bus_rd(4'd0, d);
        chk("R4 code cleared", {29'b0, d[26:24]}, 0);
        bus_rd(4'd1, d);
        chk("R8 global word", d, res_word(s0, 3'd3, 1'b0, 1'b1) | 32'h0300_0000);
        bus_rd(4'd1, d);
        chk("R8 global done cleared", {31'b0, d[31]}, 0);
        bus_rd(4'd11, d);
        chk("R7 result word", d, res_word(s0, 3'd3, 1'b0, 1'b1));
        bus_rd(4'd11, d);
        chk("R9 read clears flags", d, res_word(s0, 3'd3, 1'b0, 1'b0));
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        int s0;
        s0 = seq;
        bus_wr(4'd0, 32'h0100_0008 | PWR);
        repeat (20) @(negedge clk);
        bus_wr(4'd0, 32'h0100_0008 | PWR);
        repeat (20) @(negedge clk);
        chk("R9 two conversions", seq, s0 + 2);
        chk("R10 irq masked off", {31'b0, irq}, 0);
        bus_wr(4'd2, 32'h0000_0008);
        @(negedge clk);
        chk("R10 irq enabled", {31'b0, irq}, 1);
        bus_rd(4'd3, d);
        chk("R10 status word", d, 32'h0001_0808);
        bus_rd(4'd11, d);
        chk("R9 overrun seen", d, res_word(s0 + 1, 3'd3, 1'b1, 1'b1));
        bus_rd(4'd3, d);
        chk("R9 status cleared", d, 0);
        chk("R10 irq cleared", {31'b0, irq}, 0);
        bus_wr(4'd2, 32'h0);
    endtask

    task automatic t_edge();
        int s0;
        s0 = seq;
        bus_wr(4'd0, 32'h0C00_0002 | PWR);    // code 4 -> trig_in[2], falling
        repeat (10) @(negedge clk);
        trig_in[2] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R5 rising ignored in falling mode", seq, s0);
        trig_in[0] = 1'b1;
        repeat (10) @(negedge clk);
        trig_in[0] = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 other trigger ignored", seq, s0);
        trig_in[2] = 1'b0;
        repeat (20) @(negedge clk);
        chk("R5 falling edge starts", seq, s0 + 1);
        chk("R5 input index", {29'b0, chan_log[s0[5:0]]}, 1);
        bus_wr(4'd0, 32'h0400_0002 | PWR);    // rising
        repeat (10) @(negedge clk);
        trig_in[2] = 1'b1;
        repeat (20) @(negedge clk);
        chk("R5 rising edge starts", seq, s0 + 2);
    endtask

    task automatic t_burst();
        int s0, guard;
        s0 = seq;
        bus_wr(4'd0, 32'h0001_00A4 | PWR);    // inputs 2, 5, 7
        guard = 0;
        while (seq < s0 + 5 && guard < 500) begin @(negedge clk); guard++; end
        bus_wr(4'd0, 32'h0);
        repeat (20) @(negedge clk);
        chk("R6 burst ran", {31'b0, seq >= s0 + 5}, 1);
        chk("R6 order 0", {29'b0, chan_log[s0[5:0]]}, 2);
        chk("R6 order 1", {29'b0, chan_log[6'(s0 + 1)]}, 5);
        chk("R6 order 2", {29'b0, chan_log[6'(s0 + 2)]}, 7);
        chk("R6 wrap", {29'b0, chan_log[6'(s0 + 3)]}, 2);
        chk("R6 order 4", {29'b0, chan_log[6'(s0 + 4)]}, 5);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider();
        t_no_start();
        t_start_now();
        t_overrun();
        t_edge();
        t_burst();
        report();
    end
endmodule